// File: doc/BRIEF.md
# Byte FIFO with Dual Watermark Alerts

A synchronous store of 64 bytes that a host loads with a write strobe and empties with a read strobe. One programmable threshold of six bits sets two warnings at once. The near-full warning compares the threshold with the free space left in the buffer. The near-empty warning compares the same threshold with the number of bytes held. The host sees the threshold register, the current fill level and both warnings, so it can decide when to top up or drain the buffer without polling every byte.

A flush strobe empties the buffer in one cycle. A write that arrives when the buffer is full is dropped and sets a sticky error bit. A read from an empty buffer returns zero.

Top module: `fifo_wm_top`

## Requirements
- R1: After reset the fill level is 0, the threshold register reads 08h, the near-empty flag is 1, the near-full flag is 0, the error bit is 0 and the read data is 00h.
- R2: Bytes come out in the order they were written. `rd_data` takes the popped byte on the clock edge that samples `rd_en` and holds it until the next read.
- R3: A write to a full buffer (level 64) is dropped and leaves the level at 64. It sets `ovf_err`, which stays 1 until a flush or reset.
- R4: A read from an empty buffer sets `rd_data` to 00h and leaves the level at 0.
- R5: A write on the config port loads bits [5:0] of `cfg_wdata` as the threshold. `cfg_rdata` shows the threshold in bits [5:0] and reads 0 in bits [7:6], whatever was written there.
- R6: `hi_alert` is 1 exactly when (64 − level) ≤ threshold.
- R7: `lo_alert` is 1 exactly when level ≤ threshold.
- R8: Both flags depend only on the registered level and the registered threshold. They take their new value in the cycle after a push, a pop or a threshold write.
- R9: A push and a pop in the same cycle on a buffer that is neither empty nor full leave the level unchanged and keep the byte order.
- R10: `flush` sets the level to 0 and clears `ovf_err` in one cycle. It overrides a push or pop in the same cycle and leaves the threshold unchanged. Later data starts from fresh pointers.
- R11: On an empty buffer, a push and a pop in the same cycle return 00h and store the pushed byte, so the level becomes 1. On a full buffer, the pop proceeds, the push is dropped and `ovf_err` is set, so the level becomes 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty the buffer and clear the error bit |
| wr_en | input | 1 | Push strobe |
| wr_data | input | 8 | Byte to push |
| rd_en | input | 1 | Pop strobe |
| rd_data | output | 8 | Last popped byte (00h on an empty read) |
| cfg_we | input | 1 | Threshold register write strobe |
| cfg_wdata | input | 8 | Threshold register write data |
| cfg_rdata | output | 8 | Threshold register contents |
| level | output | 7 | Number of bytes held, 0 to 64 |
| hi_alert | output | 1 | Near-full warning |
| lo_alert | output | 1 | Near-empty warning |
| ovf_err | output | 1 | Sticky dropped-write error |

## Verification
Some properties are checked by the assertions on every cycle:
- the level bound and the dropped write at full;
- the stickiness of the error bit;
- the zero returned by an empty read;
- the unchanged level under a balanced push and pop;
- the effect of a flush;
- the threshold load;
- the two flags at the extreme levels.

Other behaviour can only be shown by the bench's scenarios, which compare every popped byte and every flag value against a reference model. These are:
- the byte order through pointer wraparound;
- the exact flag values at every level for several thresholds, including 0 and 63;
- the two corner cases of a push and pop together on an empty or a full buffer;
- the data that follows a flush.

// File: rtl/fifo_wm_pkg.sv
package fifo_wm_pkg;
    localparam int unsigned DEF_DATA_W   = 8;
    localparam int unsigned DEF_ADDR_W   = 6;
    localparam int unsigned DEF_WM_W     = 6;
    localparam int unsigned DEF_CFG_W    = 8;
    localparam logic [7:0]  DEF_WM_RESET = 8'h08;
endpackage

// File: rtl/fifo_wm_store.sv
module fifo_wm_store #(
    parameter int unsigned DATA_W = fifo_wm_pkg::DEF_DATA_W,
    parameter int unsigned ADDR_W = fifo_wm_pkg::DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/fifo_wm_ctrl.sv
module fifo_wm_ctrl #(
    parameter int unsigned DATA_W = fifo_wm_pkg::DEF_DATA_W,
    parameter int unsigned ADDR_W = fifo_wm_pkg::DEF_ADDR_W,
    localparam int unsigned CNT_W = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [ADDR_W-1:0] mem_raddr,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  level,
    output logic              ovf_err
);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(1 << ADDR_W);

    typedef struct packed {
        logic [ADDR_W-1:0] wptr;
        logic [ADDR_W-1:0] rptr;
        logic [CNT_W-1:0]  cnt;
        logic              ovf;
        logic [DATA_W-1:0] rdat;
    } ctrl_st_t;

    ctrl_st_t s_d, s_q;
    logic full, empty, push_ok, pop_ok;

    always_comb begin
        full    = (s_q.cnt == DEPTH_C);
        empty   = (s_q.cnt == '0);
        push_ok = wr_en && !full && !flush;
        pop_ok  = rd_en && !empty && !flush;
        s_d     = s_q;
        if (flush) begin
            s_d.wptr = '0;
            s_d.rptr = '0;
            s_d.cnt  = '0;
            s_d.ovf  = 1'b0;
        end else begin
            if (rd_en) begin
                s_d.rdat = empty ? '0 : mem_rdata;
            end
            if (pop_ok) begin
                s_d.rptr = s_q.rptr + 1'b1;
            end
            if (push_ok) begin
                s_d.wptr = s_q.wptr + 1'b1;
            end
            if (wr_en && full) begin
                s_d.ovf = 1'b1;
            end
            case ({push_ok, pop_ok})
                2'b10:   s_d.cnt = s_q.cnt + 1'b1;
                2'b01:   s_d.cnt = s_q.cnt - 1'b1;
                default: s_d.cnt = s_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign mem_we    = push_ok;
    assign mem_waddr = s_q.wptr;
    assign mem_raddr = s_q.rptr;
    assign rd_data   = s_q.rdat;
    assign level     = s_q.cnt;
    assign ovf_err   = s_q.ovf;

    p_level_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        level <= DEPTH_C);
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_en && !flush) |=> (level == DEPTH_C) && ovf_err);
    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_err && !flush) |=> ovf_err);
    p_empty_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_en && !wr_en && !flush) |=> (rd_data == '0) && (level == '0));
    p_balanced_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty && !full && wr_en && rd_en && !flush) |=> $stable(level));
    p_flush_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (level == '0) && !ovf_err);
endmodule

// File: rtl/fifo_wm_alerts.sv
module fifo_wm_alerts #(
    parameter int unsigned ADDR_W = fifo_wm_pkg::DEF_ADDR_W,
    parameter int unsigned WM_W   = fifo_wm_pkg::DEF_WM_W,
    parameter int unsigned CFG_W  = fifo_wm_pkg::DEF_CFG_W,
    parameter logic [CFG_W-1:0] WM_RESET = CFG_W'(fifo_wm_pkg::DEF_WM_RESET),
    localparam int unsigned CNT_W = ADDR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic [CNT_W-1:0] level,
    output logic [CFG_W-1:0] cfg_rdata,
    output logic             hi_alert,
    output logic             lo_alert
);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(1 << ADDR_W);

    typedef struct packed {
        logic [WM_W-1:0] wm;
    } wm_st_t;

    wm_st_t s_d, s_q;
    logic [CNT_W-1:0] free_room, wm_ext;

    always_comb begin
        s_d = s_q;
        if (cfg_we) begin
            s_d.wm = cfg_wdata[WM_W-1:0];
        end
        wm_ext    = CNT_W'(s_q.wm);
        free_room = DEPTH_C - level;
        hi_alert  = (free_room <= wm_ext);
        lo_alert  = (level <= wm_ext);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.wm <= WM_RESET[WM_W-1:0];
        end else begin
            s_q <= s_d;
        end
    end

    assign cfg_rdata = CFG_W'(s_q.wm);

    p_wm_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cfg_rdata == CFG_W'($past(cfg_wdata[WM_W-1:0]))));
    p_wm_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(cfg_rdata));
endmodule

// File: rtl/fifo_wm_top.sv
module fifo_wm_top #(
    parameter int unsigned DATA_W = fifo_wm_pkg::DEF_DATA_W,
    parameter int unsigned ADDR_W = fifo_wm_pkg::DEF_ADDR_W,
    parameter int unsigned WM_W   = fifo_wm_pkg::DEF_WM_W,
    parameter int unsigned CFG_W  = fifo_wm_pkg::DEF_CFG_W,
    localparam int unsigned CNT_W = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    output logic [CNT_W-1:0]  level,
    output logic              hi_alert,
    output logic              lo_alert,
    output logic              ovf_err
);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(1 << ADDR_W);

    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr, mem_raddr;
    logic [DATA_W-1:0] mem_rdata;

    fifo_wm_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_store (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (wr_data),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    fifo_wm_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .mem_rdata (mem_rdata),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_raddr (mem_raddr),
        .rd_data   (rd_data),
        .level     (level),
        .ovf_err   (ovf_err)
    );

    fifo_wm_alerts #(.ADDR_W(ADDR_W), .WM_W(WM_W), .CFG_W(CFG_W)) i_alerts (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .level     (level),
        .cfg_rdata (cfg_rdata),
        .hi_alert  (hi_alert),
        .lo_alert  (lo_alert)
    );

    p_lo_at_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (level == '0) |-> lo_alert);
    p_hi_at_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (level == DEPTH_C) |-> hi_alert);
    p_flags_track_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(level) && $stable(cfg_rdata)) |-> ($stable(hi_alert) && $stable(lo_alert)));
endmodule

// File: tb/test_fifo_wm_top.sv
module test_fifo_wm_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       flush = 1'b0, wr_en = 1'b0, rd_en = 1'b0, cfg_we = 1'b0;
    logic [7:0] wr_data = '0, cfg_wdata = '0;
    logic [7:0] rd_data, cfg_rdata;
    logic [6:0] level;
    logic       hi_alert, lo_alert, ovf_err;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [7:0] mq[$];
    int         exp_rd_q[$];
    bit         m_ovf = 0;
    int         m_wm  = 8;

    always #10 clk = ~clk;

    fifo_wm_top i_fifo_wm_top (
        .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .level(level), .hi_alert(hi_alert), .lo_alert(lo_alert),
        .ovf_err(ovf_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic check_state(input string tag);
        int sz;
        sz = mq.size();
        chk({tag, " level"}, int'(level), sz);
        chk("R6 hi_alert", int'(hi_alert), int'((64 - sz) <= m_wm));
        chk("R7 lo_alert", int'(lo_alert), int'(sz <= m_wm));
        chk("R3 ovf_err", int'(ovf_err), int'(m_ovf));
        chk("R5 cfg_rdata", int'(cfg_rdata), m_wm);
    endtask

    // monitor: compares each popped byte with the scoreboard
    always @(posedge clk) begin
        if (rst_n && rd_en && !flush) begin
            int e;
            e = exp_rd_q.pop_front();
            #2;
            chk("R2 rd_data", int'(rd_data), e);
        end
    end

    task automatic cyc(input bit w, input logic [7:0] wd, input bit r, input bit f,
                       input string tag);
        int sz;
        @(negedge clk);
        wr_en = w; wr_data = wd; rd_en = r; flush = f;
        if (f) begin
            mq.delete();
            m_ovf = 0;
        end else begin
            sz = mq.size();
            if (r) begin
                if (sz == 0) exp_rd_q.push_back(0);
                else         exp_rd_q.push_back(int'(mq.pop_front()));
            end
            if (w) begin
                if (sz == 64) m_ovf = 1;
                else          mq.push_back(wd);
            end
        end
        @(posedge clk);
        #2;
        wr_en = 0; rd_en = 0; flush = 0;
        check_state(tag);
    endtask

    task automatic set_wm(input logic [7:0] v);
        @(negedge clk);
        cfg_we = 1; cfg_wdata = v;
        m_wm = int'(v & 8'h3f);
        @(posedge clk);
        #2;
        cfg_we = 0;
        check_state("R8");
        chk("R5 upper bits zero", int'(cfg_rdata[7:6]), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        // R1: reset state
        chk("R1 level", int'(level), 0);
        chk("R1 cfg_rdata", int'(cfg_rdata), 8);
        chk("R1 lo_alert", int'(lo_alert), 1);
        chk("R1 hi_alert", int'(hi_alert), 0);
        chk("R1 ovf_err", int'(ovf_err), 0);
        chk("R1 rd_data", int'(rd_data), 0);

        for (int i = 0; i < 64; i++) cyc(1, 8'(i * 5 + 3), 0, 0, "R2 fill");
        cyc(1, 8'hAA, 0, 0, "R3 write when full");
        cyc(0, 8'h00, 0, 0, "R3 sticky");
        set_wm(8'hFF);
        cyc(1, 8'h55, 1, 0, "R11 full push+pop");
        for (int i = 0; i < 70 && mq.size() > 0; i++) cyc(0, 8'h00, 1, 0, "R2 drain");
        cyc(0, 8'h00, 1, 0, "R4 empty read");
        cyc(1, 8'h77, 1, 0, "R11 empty push+pop");
        set_wm(8'hC5);
        for (int i = 0; i < 10; i++) cyc(1, 8'(8'h90 + i), 0, 0, "R8 push");
        for (int i = 0; i < 8; i++)  cyc(1, 8'(8'h40 + i), 1, 0, "R9 balanced");
        set_wm(8'h00);
        for (int i = 0; i < 5; i++)  cyc(0, 8'h00, 1, 0, "R8 pop");
        cyc(1, 8'h11, 1, 1, "R10 flush");
        chk("R10 threshold kept", int'(cfg_rdata), 0);
        set_wm(8'h3F);
        for (int i = 0; i < 3; i++) cyc(1, 8'(8'hE0 + i), 0, 0, "R10 after flush");
        for (int i = 0; i < 4; i++) cyc(0, 8'h00, 1, 0, "R10 read after flush");
        set_wm(8'h20);
        for (int i = 0; i < 40; i++) cyc(1, 8'(i * 7), 0, 0, "R6 threshold 32");
        for (int i = 0; i < 40; i++) cyc(0, 8'h00, 1, 0, "R7 threshold 32");
        repeat (2) @(posedge clk);
        done = 1;
        report();
    end
endmodule